// File: doc/BRIEF.md
# Transposable Broadcast MAC Array

This block is a square array of fixed-point multiply-accumulate cells that computes a matrix-vector product by summing column-scaled partial vectors. An activation vector is held in a line buffer. Element r of that vector is broadcast to every cell of array row r. Each cell multiplies the activation by its own stored weight. Partial sums pass downward through registers in each column, and an accumulator below the column collects the finished sum.

Weights arrive one wide word at a time. Each word holds one matrix row. In column-load mode the word fills one array column, so the array computes W·a. In row-load mode the same word fills one array row, so the array computes Wᵀ·e. One weight image therefore serves both the forward pass and the backward pass, and the matrix is never stored twice.

A start can keep the previous accumulator contents. This lets tiles of a matrix larger than the array be summed into the same output block. Activation functions and the memories that feed the array sit outside this block.

Top module: `tmac_array`

## Requirements
- R1: With `wload_mode_i`=0 (column load), word element k (bits k*WW+WW-1 down to k*WW) is stored in the cell at array row k, column `wload_idx_i`. After a run, result element c (bits c*ACCW+ACCW-1 down to c*ACCW) equals the sum over r of act[r]*cell[r][c], where act[r] is element r of the loaded line buffer.
- R2: With `wload_mode_i`=1 (row load), word element k is stored in the cell at array row `wload_idx_i`, column k. Loading matrix row p into array row p makes the result equal to the transposed product.
- R3: Weights and activations are signed two's complement. A load changes only the cells it addresses, and all other cells keep their weights.
- R4: `done_o` is high for exactly one cycle. It rises N+1 clock edges after the edge that accepts `start_i`.
- R5: A start with `accumulate_i`=0 clears every accumulator at the accepting edge. A start with `accumulate_i`=1 adds the new column sums to the values already held.
- R6: While no run is in progress and no start is accepted, `result_o` holds its value.
- R7: While a run is in progress, weight loads, line-buffer loads and further starts are ignored.
- R8: Accumulators hold the full N-term sum of the most negative operands without overflow, and they keep guard bits for repeated tile accumulation.
- R9: Reset clears all weights, the line buffer and the accumulators, and holds `done_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wload_valid_i | input | 1 | Write one weight word this cycle |
| wload_mode_i | input | 1 | 0: word fills a column, 1: word fills a row |
| wload_idx_i | input | IW | Column or row index of the write |
| wload_data_i | input | N*WW | Weight word, element k in slice k |
| act_load_i | input | 1 | Capture a vector into the line buffer |
| act_data_i | input | N*AW | Activation vector, element r feeds array row r |
| start_i | input | 1 | Begin a run |
| accumulate_i | input | 1 | Keep accumulator contents on start |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | N*ACCW | Accumulated column sums, element c in slice c |

## Verification
The assertions assume that `start_i` and the load strobes are plain single-cycle requests. They also assume that `wload_idx_i` stays below N when a load is issued. The stimulus drives every request for exactly one cycle on the falling clock edge and uses only indices inside the array. It issues loads and starts during a run only on purpose, to show that they are dropped. The scoreboard keeps its own image of the array cells, updated with the column or row steering rule for each accepted load. From that image it derives the expected column sums and the completion cycle.

// File: rtl/tmac_pkg.sv
package tmac_pkg;

  typedef enum logic {
    LOAD_COL = 1'b0,
    LOAD_ROW = 1'b1
  } load_mode_e;

  function automatic int psum_width(input int aw, input int ww, input int n);
    return aw + ww + $clog2(n);
  endfunction

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tmac_weight_bank.sv
module tmac_weight_bank #(
  parameter int N  = 16,
  parameter int WW = 32,
  localparam int IW = tmac_pkg::idx_width(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              mode_i,
  input  logic [IW-1:0]     idx_i,
  input  logic [N*WW-1:0]   data_i,
  output logic [N*N*WW-1:0] w_o
);
  import tmac_pkg::*;

  load_mode_e mode;
  assign mode = load_mode_e'(mode_i);

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      logic [WW-1:0] w_q;
      logic          hit_col, hit_row;

      // column load takes word element r, row load takes word element c
      assign hit_col = we_i && (mode == LOAD_COL) && (idx_i == IW'(c));
      assign hit_row = we_i && (mode == LOAD_ROW) && (idx_i == IW'(r));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      w_q <= '0;
        else if (hit_col) w_q <= data_i[r*WW +: WW];
        else if (hit_row) w_q <= data_i[c*WW +: WW];
      end

      assign w_o[(r*N+c)*WW +: WW] = w_q;
    end
  end

endmodule

// File: rtl/tmac_act_buf.sv
module tmac_act_buf #(
  parameter int N  = 16,
  parameter int AW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [N*AW-1:0] data_i,
  output logic [N*AW-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= data_i;
  end

endmodule

// File: rtl/tmac_column.sv
module tmac_column #(
  parameter int N  = 16,
  parameter int AW = 32,
  parameter int WW = 32,
  localparam int PW  = AW + WW,
  localparam int PSW = tmac_pkg::psum_width(AW, WW, N)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N*AW-1:0]       acts_i,
  input  logic [N*WW-1:0]       wcol_i,
  output logic signed [PSW-1:0] sum_o
);

  logic signed [PSW-1:0] psum_q [N];

  for (genvar r = 0; r < N; r++) begin : g_cell
    logic signed [PW-1:0]  a_ext, w_ext, prod;
    logic signed [PSW-1:0] prod_ext, carry_in;

    assign a_ext    = PW'($signed(acts_i[r*AW +: AW]));
    assign w_ext    = PW'($signed(wcol_i[r*WW +: WW]));
    assign prod     = a_ext * w_ext;
    assign prod_ext = PSW'(prod);

    if (r == 0) begin : g_top
      assign carry_in = '0;
    end else begin : g_chain
      assign carry_in = psum_q[r-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) psum_q[r] <= '0;
      else         psum_q[r] <= carry_in + prod_ext;
    end
  end

  assign sum_o = psum_q[N-1];

endmodule

// File: rtl/tmac_ctrl.sv
module tmac_ctrl #(
  parameter int N = 16,
  localparam int CW = $clog2(N + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic accumulate_i,
  output logic busy_o,
  output logic clr_o,
  output logic add_o,
  output logic done_o
);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          accept;

  assign accept = start_i && !busy_q;
  assign clr_o  = accept && !accumulate_i;
  // bottom of the chain is valid N edges after acceptance
  assign add_o  = busy_q && (cnt_q == CW'(N));
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= add_o;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (add_o) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tmac_array.sv
module tmac_array #(
  parameter int N         = 16,
  parameter int WW        = 32,
  parameter int AW        = 32,
  parameter int ACC_GUARD = 4,
  localparam int IW   = tmac_pkg::idx_width(N),
  localparam int PSW  = tmac_pkg::psum_width(AW, WW, N),
  localparam int ACCW = PSW + ACC_GUARD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wload_valid_i,
  input  logic              wload_mode_i,
  input  logic [IW-1:0]     wload_idx_i,
  input  logic [N*WW-1:0]   wload_data_i,
  input  logic              act_load_i,
  input  logic [N*AW-1:0]   act_data_i,
  input  logic              start_i,
  input  logic              accumulate_i,
  output logic              done_o,
  output logic [N*ACCW-1:0] result_o
);

  logic              busy, clr, add;
  logic [N*N*WW-1:0] w_flat;
  logic [N*AW-1:0]   act_q;

  tmac_ctrl #(.N(N)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .accumulate_i (accumulate_i),
    .busy_o       (busy),
    .clr_o        (clr),
    .add_o        (add),
    .done_o       (done_o)
  );

  tmac_weight_bank #(.N(N), .WW(WW)) u_wbank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wload_valid_i && !busy),
    .mode_i (wload_mode_i),
    .idx_i  (wload_idx_i),
    .data_i (wload_data_i),
    .w_o    (w_flat)
  );

  tmac_act_buf #(.N(N), .AW(AW)) u_abuf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (act_load_i && !busy),
    .data_i (act_data_i),
    .q_o    (act_q)
  );

  for (genvar c = 0; c < N; c++) begin : g_col
    logic [N*WW-1:0]       wcol;
    logic signed [PSW-1:0] col_sum;
    logic signed [ACCW-1:0] acc_q;

    for (genvar r = 0; r < N; r++) begin : g_pick
      assign wcol[r*WW +: WW] = w_flat[(r*N+c)*WW +: WW];
    end

    tmac_column #(.N(N), .AW(AW), .WW(WW)) u_column (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .acts_i (act_q),
      .wcol_i (wcol),
      .sum_o  (col_sum)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  acc_q <= '0;
      else if (clr) acc_q <= '0;
      else if (add) acc_q <= acc_q + ACCW'(col_sum);
    end

    assign result_o[c*ACCW +: ACCW] = acc_q;
  end

endmodule

// File: rtl/tmac_chk.sv
module tmac_chk #(
  parameter int N    = 16,
  parameter int WW   = 32,
  parameter int AW   = 32,
  parameter int ACCW = 72
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              accumulate_i,
  input logic              wload_valid_i,
  input logic              act_load_i,
  input logic              busy,
  input logic              done_o,
  input logic [N*ACCW-1:0] result_o,
  input logic [N*N*WW-1:0] w_flat,
  input logic [N*AW-1:0]   act_q
);

  logic [15:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lat_q <= '0;
    else if (start_i && !busy)  lat_q <= '0;
    else if (lat_q != 16'hffff) lat_q <= lat_q + 1'b1;
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  done_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == 16'(N + 1)));

  // R5
  clear_on_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy && !accumulate_i) |=> (result_o == '0));

  // R6
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !start_i) |=> $stable(result_o));

  // R7
  weight_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && wload_valid_i) |=> $stable(w_flat));

  // R7
  act_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && act_load_i) |=> $stable(act_q));

endmodule

bind tmac_array tmac_chk #(.N(N), .WW(WW), .AW(AW), .ACCW(ACCW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .accumulate_i  (accumulate_i),
  .wload_valid_i (wload_valid_i),
  .act_load_i    (act_load_i),
  .busy          (busy),
  .done_o        (done_o),
  .result_o      (result_o),
  .w_flat        (w_flat),
  .act_q         (act_q)
);

// File: tb/tmac_array_test.sv
module tmac_array_test;
  localparam int N    = 16;
  localparam int WW   = 32;
  localparam int AW   = 32;
  localparam int IW   = 4;
  localparam int ACCW = AW + WW + 4 + 4;
  localparam int RW   = N * ACCW;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wload_valid_i = 1'b0;
  logic              wload_mode_i = 1'b0;
  logic [IW-1:0]     wload_idx_i = '0;
  logic [N*WW-1:0]   wload_data_i = '0;
  logic              act_load_i = 1'b0;
  logic [N*AW-1:0]   act_data_i = '0;
  logic              start_i = 1'b0;
  logic              accumulate_i = 1'b0;
  logic              done_o;
  logic [RW-1:0]     result_o;

  always #2.5 clk_i = ~clk_i;

  tmac_array uut (.*);

  typedef struct {
    logic [RW-1:0] exp;
    int            t0;
    string         tag;
  } item_t;

  item_t sbq[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic signed [WW-1:0]   mdl [N][N];
  logic signed [AW-1:0]   amdl [N];
  logic signed [ACCW-1:0] accm [N];
  logic [RW-1:0] last_exp = '0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk_vec(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s result actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load_w(input bit mode, input int idx, input int d [N], input bit ign);
    @(negedge clk_i);
    wload_valid_i = 1'b1;
    wload_mode_i  = mode;
    wload_idx_i   = IW'(idx);
    for (int k = 0; k < N; k++) wload_data_i[k*WW +: WW] = d[k];
    if (!ign)
      for (int k = 0; k < N; k++) begin
        if (mode == 1'b0) mdl[k][idx] = d[k];
        else              mdl[idx][k] = d[k];
      end
    @(negedge clk_i);
    wload_valid_i = 1'b0;
  endtask

  task automatic load_a(input int d [N], input bit ign);
    @(negedge clk_i);
    act_load_i = 1'b1;
    for (int k = 0; k < N; k++) act_data_i[k*AW +: AW] = d[k];
    if (!ign) for (int k = 0; k < N; k++) amdl[k] = d[k];
    @(negedge clk_i);
    act_load_i = 1'b0;
  endtask

  task automatic start_run(input bit acc, input string tag);
    item_t it;
    @(negedge clk_i);
    start_i      = 1'b1;
    accumulate_i = acc;
    for (int c = 0; c < N; c++) begin
      logic signed [ACCW-1:0] s;
      s = '0;
      for (int r = 0; r < N; r++) s += ACCW'(amdl[r]) * ACCW'(mdl[r][c]);
      accm[c] = acc ? accm[c] + s : s;
      it.exp[c*ACCW +: ACCW] = accm[c];
    end
    it.t0  = cyc;
    it.tag = tag;
    sbq.push_back(it);
    last_exp = it.exp;
    @(negedge clk_i);
    start_i = 1'b0;
    // R5: clear visible right after the accepting edge
    if (!acc) chk_vec("R5 clear", result_o, '0);
  endtask

  task automatic wait_idle();
    while (sbq.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // monitor
  initial begin
    bit prev_done = 1'b0;
    @(posedge rst_ni);
    forever begin
      @(negedge clk_i);
      if (prev_done) chk_int("R4", "done width", int'(done_o), 0);
      if (done_o) begin
        if (sbq.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7 unexpected done actual=1 expected=0");
        end else begin
          item_t it;
          it = sbq.pop_front();
          chk_vec(it.tag, result_o, it.exp);
          chk_int("R4", "latency", cyc - it.t0, N + 2);
        end
      end
      prev_done = done_o;
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d [N];
    for (int r = 0; r < N; r++) begin
      amdl[r] = '0; accm[r] = '0;
      for (int c = 0; c < N; c++) mdl[r][c] = '0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R9
    chk_vec("R9 reset result", result_o, '0);
    chk_int("R9", "reset done", int'(done_o), 0);
    for (int k = 0; k < N; k++) d[k] = k * 1000 + 7;
    load_a(d, 1'b0);
    start_run(1'b0, "R9 weights zero");
    wait_idle();

    // R1: forward, matrix row p into column p
    for (int p = 0; p < N; p++) begin
      for (int k = 0; k < N; k++) d[k] = (p * 131 + k * 17 - 1100) * 9973;
      load_w(1'b0, p, d, 1'b0);
    end
    for (int k = 0; k < N; k++) d[k] = k * 12345 - 90000;
    load_a(d, 1'b0);
    start_run(1'b0, "R1 forward");
    wait_idle();

    // R2: backward, matrix row p into row p
    for (int p = 0; p < N; p++) begin
      for (int k = 0; k < N; k++) d[k] = (p * 29 - k * 211 + 300) * 7717;
      load_w(1'b1, p, d, 1'b0);
    end
    for (int k = 0; k < N; k++) d[k] = 50000 - k * k * 997;
    load_a(d, 1'b0);
    start_run(1'b0, "R2 backward");
    wait_idle();

    // R5: second tile accumulates
    for (int k = 0; k < N; k++) d[k] = (k % 3) * 400000 - 333333;
    load_a(d, 1'b0);
    start_run(1'b1, "R5 tile accumulate");
    wait_idle();

    // R3: signed extremes in one column, rest untouched
    for (int k = 0; k < N; k++) d[k] = (k % 2) ? 32'sh7fff_ffff : int'(32'h8000_0000);
    load_w(1'b0, 5, d, 1'b0);
    start_run(1'b0, "R3 partial signed");
    wait_idle();

    // R7: loads and starts during a run are dropped
    start_run(1'b0, "R7 busy run");
    for (int k = 0; k < N; k++) d[k] = 123456 + k;
    load_w(1'b1, 2, d, 1'b1);
    load_a(d, 1'b1);
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    wait_idle();
    start_run(1'b0, "R7 state kept");
    wait_idle();

    // R6: held while idle
    repeat (6) @(negedge clk_i);
    chk_vec("R6 hold", result_o, last_exp);

    // R8: most negative operands everywhere
    for (int p = 0; p < N; p++) begin
      for (int k = 0; k < N; k++) d[k] = int'(32'h8000_0000);
      load_w(1'b1, p, d, 1'b0);
    end
    load_a(d, 1'b0);
    start_run(1'b0, "R8 full range");
    wait_idle();
    start_run(1'b1, "R8 guard");
    wait_idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule